// File: doc/BRIEF.md
# Merged Instruction Line Fetch Tracker

This block sits between the per-thread instruction queues of a multithreaded execution unit and its instruction cache. Each of eight hardware threads owns a queue of two line-sized slots. When a slot is empty the thread asks for the next cacheline ahead of need. The tracker keeps one table of lines that are in flight, and each line carries an ownership bitmap with one bit per thread and slot. A request for a line that is already in flight never reaches the cache; it only adds the requester's bit to the line's bitmap. When a line comes back, a single cycle delivers it to every slot whose bit is set.

Requests that do need a new fetch compete for the one cache request port. The thread that has waited longest wins; threads that arrive in the same cycle are ordered by index. A thread that takes a branch raises its flush input. This removes the thread's claims from every line in flight, so data returning later is not written into that thread's queue. A line with no claims left is retired at once. If the table is full, a request that misses waits until a line is retired. If a request names the line being returned in that same cycle, the return data goes straight to the requester and nothing is allocated.

Requests are level signals: a thread holds `req_valid` until `req_ack` comes back. The cache port has no back-pressure, and a returning line is written into the owning slots during its return cycle. `fill_mask` bit `t*2+s` selects slot `s` of thread `t`.

Top module: `ifq_fetch_merge`

## Requirements
- R1: If a request misses the table and the returned line, and the table has a free entry, the block raises `ic_req_valid` with `ic_req_addr` equal to the requested line and asserts that thread's `req_ack`, all in the same cycle. Only requests that are present receive an acknowledge.
- R2: At most one fetch is issued per cycle. Other requesters in that cycle whose address equals the fetched line are acknowledged and recorded as owners of the new entry. Requesters for different lines keep waiting.
- R3: A request whose line matches an entry in flight is acknowledged with no fetch, and its slot becomes an owner of that entry. A line that was fetched is never fetched again in the very next cycle.
- R4: When `ret_valid` carries the address of an entry in flight, `fill_mask` sets exactly that entry's owner bits (bit `t*2+s` for slot `s` of thread `t`) in the same cycle, and `fill_data` equals `ret_data`. The entry is then freed, so a second return of that address fills nothing.
- R5: Among requesters that need a fetch, the one that has been waiting the longest wins the port. Requesters that first appeared in the same cycle are served lowest thread index first.
- R6: While `flush[t]` is high, thread `t` gets no acknowledge and no `fill_mask` bit. Its ownership bits are cleared from every entry, so later returns do not fill its slots.
- R7: An entry whose ownership bits have all been cleared by flushes is freed. A later request for that line issues a fresh fetch.
- R8: When all table entries are in flight, a missing request receives no acknowledge and causes no fetch. An entry freed by a return can be allocated from the following cycle.
- R9: A request whose address equals `ret_addr` in a return cycle gets its `fill_mask` bit and an acknowledge in that cycle. No fetch is issued and no entry is allocated.
- R10: After reset the table is empty. With no requests the block raises no fetch, no acknowledge and no fill, and a return that matches no entry fills nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NTHR | Per-thread fetch request, held until acknowledged |
| req_addr | input | NTHR*AW | Per-thread line address, thread t at bits t*AW +: AW |
| req_slot | input | NTHR*SW | Per-thread target queue slot |
| req_ack | output | NTHR | Request taken (fetched, merged or filled directly) |
| flush | input | NTHR | Per-thread branch flush |
| ic_req_valid | output | 1 | Fetch issued to the instruction cache |
| ic_req_addr | output | AW | Line address of the fetch |
| ret_valid | input | 1 | Line returned from the cache |
| ret_addr | input | AW | Address of the returned line |
| ret_data | input | LINE_W | Returned line contents |
| fill_mask | output | NTHR*NSLOT | Queue slots written this cycle |
| fill_data | output | LINE_W | Line data written to the selected slots |

## Verification
The bench drives each thread and slot with its own line and checks that the return sets exactly one `fill_mask` bit at `t*2+s`; a swapped slot bit or a wrong bit layout fails at once. It makes all eight threads request one line in the same cycle, and then mixes shared and distinct lines, to show that only one fetch leaves and that every acknowledged requester is filled. A design that fetched per thread or dropped merged owners would show extra fetches or missing bits. Ordering is tested with a request left waiting while a younger one arrives, which catches an index-priority arbiter. Flush during ownership, flush during a return, a full table with a stalled miss, and a request that coincides with the return of its line each expose a design that fills a flushed slot, leaks an entry, allocates past full, or fetches a line already on the return bus.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

  // position of a (thread, slot) pair inside an ownership bitmap
  function automatic int unsigned own_pos(input int unsigned thr,
                                          input int unsigned slot,
                                          input int unsigned nslot);
    return thr * nslot + slot;
  endfunction

  // true when candidate i should be served before candidate j
  function automatic logic served_first(input logic old_rel,
                                        input logic i_new,
                                        input logic j_new,
                                        input int unsigned i,
                                        input int unsigned j);
    if (i == j)                 return 1'b0;
    else if (!i_new && !j_new)  return old_rel;
    else if (!i_new)            return 1'b1;
    else if (!j_new)            return 1'b0;
    else                        return (i < j);
  endfunction

endpackage

// File: rtl/ifq_age_arb.sv
module ifq_age_arb
  import ifq_pkg::*;
#(
  parameter int NTHR = 8,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTHR-1:0] req_valid,
  input  logic [NTHR-1:0] flush,
  input  logic [NTHR-1:0] ack,
  input  logic [NTHR-1:0] cand,
  output logic            win_valid,
  output logic [TW-1:0]   win_idx
);

  logic [NTHR-1:0] pend_q;
  logic [NTHR-1:0] arrive;
  logic [NTHR-1:0] before_q [NTHR];
  logic [NTHR-1:0] before_n [NTHR];

  assign arrive = req_valid & ~pend_q;

  always_comb begin
    for (int i = 0; i < NTHR; i++) begin
      for (int j = 0; j < NTHR; j++) begin
        before_n[i][j] = served_first(before_q[i][j], arrive[i], arrive[j],
                                      i, j);
      end
    end
  end

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int w = 0; w < NTHR; w++) begin
      logic beats_all;
      beats_all = cand[w];
      for (int j = 0; j < NTHR; j++) begin
        if (j != w && cand[j] && !before_n[w][j]) beats_all = 1'b0;
      end
      if (beats_all && !win_valid) begin
        win_valid = 1'b1;
        win_idx   = TW'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int i = 0; i < NTHR; i++) before_q[i] <= '0;
    end else begin
      pend_q <= req_valid & ~ack & ~flush;
      for (int i = 0; i < NTHR; i++) before_q[i] <= before_n[i];
    end
  end

endmodule

// File: rtl/ifq_line_table.sv
module ifq_line_table #(
  parameter int NTHR  = 8,
  parameter int NSLOT = 2,
  parameter int NENT  = 8,
  parameter int AW    = 26,
  localparam int OWN_W = NTHR * NSLOT,
  localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NTHR*AW-1:0]    lk_addr,
  output logic [NTHR-1:0]       lk_hit,
  output logic [NTHR*IDX_W-1:0] lk_idx,
  input  logic [AW-1:0]         ret_addr,
  output logic                  ret_hit,
  output logic [OWN_W-1:0]      ret_own,
  input  logic                  ret_clear,
  input  logic [NTHR-1:0]       merge_en,
  input  logic [OWN_W-1:0]      slot_bits,
  input  logic [OWN_W-1:0]      flush_bits,
  input  logic                  alloc_en,
  input  logic [AW-1:0]         alloc_addr,
  input  logic [OWN_W-1:0]      alloc_own,
  output logic                  all_busy
);

  logic [OWN_W-1:0] own_q [NENT];
  logic [AW-1:0]    tag_q [NENT];
  logic [OWN_W-1:0] own_n [NENT];
  logic [NENT-1:0]  busy;
  logic [IDX_W-1:0] ret_idx;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    for (int e = 0; e < NENT; e++) busy[e] = |own_q[e];
  end
  assign all_busy = &busy;

  // per-thread lookup
  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      lk_hit[t]                  = 1'b0;
      lk_idx[t*IDX_W +: IDX_W]   = '0;
      for (int e = 0; e < NENT; e++) begin
        if (busy[e] && tag_q[e] == lk_addr[t*AW +: AW] && !lk_hit[t]) begin
          lk_hit[t]                = 1'b1;
          lk_idx[t*IDX_W +: IDX_W] = IDX_W'(e);
        end
      end
    end
  end

  // return lookup and free-slot search
  always_comb begin
    ret_hit  = 1'b0;
    ret_idx  = '0;
    ret_own  = '0;
    free_idx = '0;
    for (int e = NENT - 1; e >= 0; e--) begin
      if (!busy[e]) free_idx = IDX_W'(e);
    end
    for (int e = 0; e < NENT; e++) begin
      if (busy[e] && tag_q[e] == ret_addr && !ret_hit) begin
        ret_hit = 1'b1;
        ret_idx = IDX_W'(e);
        ret_own = own_q[e];
      end
    end
  end

  // ownership update: flush, merge, retire, allocate
  always_comb begin
    for (int e = 0; e < NENT; e++) begin
      own_n[e] = own_q[e] & ~flush_bits;
      for (int t = 0; t < NTHR; t++) begin
        if (merge_en[t] && lk_idx[t*IDX_W +: IDX_W] == IDX_W'(e))
          own_n[e][t*NSLOT +: NSLOT] = own_n[e][t*NSLOT +: NSLOT] |
                                       slot_bits[t*NSLOT +: NSLOT];
      end
      if (ret_clear && ret_idx == IDX_W'(e)) own_n[e] = '0;
      if (alloc_en && free_idx == IDX_W'(e)) own_n[e] = alloc_own;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) begin
        own_q[e] <= '0;
        tag_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < NENT; e++) begin
        own_q[e] <= own_n[e];
        if (alloc_en && free_idx == IDX_W'(e)) tag_q[e] <= alloc_addr;
      end
    end
  end

endmodule

// File: rtl/ifq_fetch_merge.sv
module ifq_fetch_merge
  import ifq_pkg::*;
#(
  parameter int NTHR   = 8,
  parameter int NSLOT  = 2,
  parameter int NENT   = 8,
  parameter int AW     = 26,
  parameter int LINE_W = 512,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int OWN_W = NTHR * NSLOT,
  localparam int TW    = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NTHR-1:0]     req_valid,
  input  logic [NTHR*AW-1:0]  req_addr,
  input  logic [NTHR*SW-1:0]  req_slot,
  output logic [NTHR-1:0]     req_ack,
  input  logic [NTHR-1:0]     flush,
  output logic                ic_req_valid,
  output logic [AW-1:0]       ic_req_addr,
  input  logic                ret_valid,
  input  logic [AW-1:0]       ret_addr,
  input  logic [LINE_W-1:0]   ret_data,
  output logic [OWN_W-1:0]    fill_mask,
  output logic [LINE_W-1:0]   fill_data
);

  logic [OWN_W-1:0]      slot_bits, flush_bits, alloc_own, ret_own;
  logic [NTHR-1:0]       live, ret_match, hit_t, miss, same_win, lk_hit;
  logic [NTHR*IDX_W-1:0] lk_idx;
  logic                  ret_hit, ret_clear, tbl_full;
  logic                  win_valid, fetch_fire;
  logic [TW-1:0]         win_idx;
  logic [AW-1:0]         alloc_addr;

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      for (int s = 0; s < NSLOT; s++) begin
        slot_bits[own_pos(t, s, NSLOT)]  = (req_slot[t*SW +: SW] == SW'(s));
        flush_bits[own_pos(t, s, NSLOT)] = flush[t];
      end
    end
  end

  assign live = req_valid & ~flush;

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      ret_match[t] = live[t] && ret_valid && (req_addr[t*AW +: AW] == ret_addr);
      hit_t[t]     = live[t] && !ret_match[t] && lk_hit[t];
      miss[t]      = live[t] && !ret_match[t] && !lk_hit[t];
    end
  end

  ifq_age_arb #(.NTHR(NTHR)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .flush     (flush),
    .ack       (req_ack),
    .cand      (miss),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  assign fetch_fire = win_valid && !tbl_full;
  assign alloc_addr = req_addr[win_idx*AW +: AW];

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      same_win[t] = miss[t] && fetch_fire && (req_addr[t*AW +: AW] == alloc_addr);
      for (int s = 0; s < NSLOT; s++)
        alloc_own[own_pos(t, s, NSLOT)] = same_win[t] && slot_bits[own_pos(t, s, NSLOT)];
    end
  end

  assign ret_clear = ret_valid && ret_hit;

  ifq_line_table #(
    .NTHR(NTHR), .NSLOT(NSLOT), .NENT(NENT), .AW(AW)
  ) u_tbl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_addr    (req_addr),
    .lk_hit     (lk_hit),
    .lk_idx     (lk_idx),
    .ret_addr   (ret_addr),
    .ret_hit    (ret_hit),
    .ret_own    (ret_own),
    .ret_clear  (ret_clear),
    .merge_en   (hit_t),
    .slot_bits  (slot_bits),
    .flush_bits (flush_bits),
    .alloc_en   (fetch_fire),
    .alloc_addr (alloc_addr),
    .alloc_own  (alloc_own),
    .all_busy   (tbl_full)
  );

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      for (int s = 0; s < NSLOT; s++) begin
        fill_mask[own_pos(t, s, NSLOT)] =
          (ret_clear && ret_own[own_pos(t, s, NSLOT)] && !flush[t]) ||
          (ret_match[t] && slot_bits[own_pos(t, s, NSLOT)]);
      end
    end
  end

  assign req_ack      = ret_match | hit_t | same_win;
  assign ic_req_valid = fetch_fire;
  assign ic_req_addr  = alloc_addr;
  assign fill_data    = ret_data;

endmodule

// File: rtl/ifq_fetch_merge_chk.sv
module ifq_fetch_merge_chk #(
  parameter int NTHR  = 8,
  parameter int NSLOT = 2,
  parameter int AW    = 26
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NTHR-1:0]       req_valid,
  input logic [NTHR-1:0]       req_ack,
  input logic [NTHR-1:0]       flush,
  input logic                  ic_req_valid,
  input logic [AW-1:0]         ic_req_addr,
  input logic                  ret_valid,
  input logic [AW-1:0]         ret_addr,
  input logic [NTHR*NSLOT-1:0] fill_mask,
  input logic                  tbl_full
);

  logic [NTHR*NSLOT-1:0] flush_x;
  logic                  past_ok;

  always_comb begin
    for (int t = 0; t < NTHR; t++)
      for (int s = 0; s < NSLOT; s++) flush_x[t*NSLOT+s] = flush[t];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack & ~req_valid) == '0); // R1
  AST_FETCH_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ic_req_valid |-> (req_ack != '0)); // R1
  AST_NO_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ic_req_valid && $past(ic_req_valid)) |-> (ic_req_addr != $past(ic_req_addr))); // R3
  AST_FILL_NEEDS_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_mask != '0) |-> ret_valid); // R4
  AST_FLUSH_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack & flush) == '0); // R6
  AST_FLUSH_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_mask & flush_x) == '0); // R6
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_full |-> !ic_req_valid); // R8
  AST_NO_DUP_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ic_req_valid |-> !(ret_valid && ret_addr == ic_req_addr)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |-> (req_ack == '0 && !ic_req_valid)); // R10

endmodule

bind ifq_fetch_merge ifq_fetch_merge_chk #(
  .NTHR(NTHR), .NSLOT(NSLOT), .AW(AW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ack      (req_ack),
  .flush        (flush),
  .ic_req_valid (ic_req_valid),
  .ic_req_addr  (ic_req_addr),
  .ret_valid    (ret_valid),
  .ret_addr     (ret_addr),
  .fill_mask    (fill_mask),
  .tbl_full     (tbl_full)
);

// File: tb/ifq_fetch_merge_test.sv
module ifq_fetch_merge_test;
  localparam int NT = 8;
  localparam int AW = 26;
  localparam int LW = 512;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NT-1:0]   req_valid;
  logic [NT*AW-1:0] req_addr;
  logic [NT-1:0]   req_slot;
  logic [NT-1:0]   req_ack;
  logic [NT-1:0]   flush;
  logic            ic_req_valid;
  logic [AW-1:0]   ic_req_addr;
  logic            ret_valid;
  logic [AW-1:0]   ret_addr;
  logic [LW-1:0]   ret_data;
  logic [2*NT-1:0] fill_mask;
  logic [LW-1:0]   fill_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ifq_fetch_merge uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_slot(req_slot), .req_ack(req_ack), .flush(flush),
    .ic_req_valid(ic_req_valid), .ic_req_addr(ic_req_addr),
    .ret_valid(ret_valid), .ret_addr(ret_addr), .ret_data(ret_data),
    .fill_mask(fill_mask), .fill_data(fill_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    req_valid = '0; req_addr = '0; req_slot = '0;
    flush = '0; ret_valid = 1'b0; ret_addr = '0; ret_data = '0;
  endtask

  task automatic nxt();
    @(negedge clk);
    clr();
  endtask

  task automatic put(input int t, input logic [AW-1:0] a, input int s);
    req_valid[t] = 1'b1;
    req_addr[t*AW +: AW] = a;
    req_slot[t] = s[0];
  endtask

  task automatic give(input logic [AW-1:0] a);
    ret_valid = 1'b1;
    ret_addr  = a;
    ret_data  = {16{6'h0, a}};
  endtask

  function automatic logic [15:0] bit_of(input int t, input int s);
    return 16'(1) << (t*2 + s);
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: quiet after reset, empty table
    #1;
    chk("R10 no fetch", ic_req_valid, 0);
    chk("R10 no ack", req_ack, 0);
    chk("R10 no fill", fill_mask, 0);
    nxt(); give(26'h3AB); #1;
    chk("R10 stray return", fill_mask, 0);

    // R1: single miss fetches at once
    nxt(); put(0, 26'h100, 0); #1;
    chk("R1 fetch", ic_req_valid, 1);
    chk("R1 addr", ic_req_addr, 26'h100);
    chk("R1 ack", req_ack, 8'h01);
    // R3: merge into line in flight
    nxt(); put(3, 26'h100, 1); #1;
    chk("R3 no fetch", ic_req_valid, 0);
    chk("R3 ack", req_ack, 8'h08);
    // R4: delivery to both owners
    nxt(); give(26'h100); #1;
    chk("R4 owners", fill_mask, bit_of(0,0) | bit_of(3,1));
    chk("R4 data", fill_data[63:0], {2{6'h0, 26'h100}});
    nxt(); give(26'h100); #1;
    chk("R4 freed", fill_mask, 0);

    // R5: oldest first, ties by index
    nxt(); put(5, 26'h200, 0); put(2, 26'h201, 0); #1;
    chk("R5 tie addr", ic_req_addr, 26'h201);
    chk("R5 tie ack", req_ack, 8'h04);
    nxt(); put(5, 26'h200, 0); put(1, 26'h202, 0); #1;
    chk("R5 older wins addr", ic_req_addr, 26'h200);
    chk("R5 older wins ack", req_ack, 8'h20);
    nxt(); put(1, 26'h202, 0); #1;
    chk("R5 last", ic_req_addr, 26'h202);
    nxt(); give(26'h201); #1; chk("R5 fill t2", fill_mask, bit_of(2,0));
    nxt(); give(26'h200); #1; chk("R5 fill t5", fill_mask, bit_of(5,0));
    nxt(); give(26'h202); #1; chk("R5 fill t1", fill_mask, bit_of(1,0));

    // R2: all threads on one line
    begin
      logic [15:0] exp_m;
      exp_m = '0;
      nxt();
      for (int t = 0; t < NT; t++) begin
        put(t, 26'h300, t & 1);
        exp_m |= bit_of(t, t & 1);
      end
      #1;
      chk("R2 one fetch", ic_req_valid, 1);
      chk("R2 all acked", req_ack, 8'hFF);
      nxt(); give(26'h300); #1;
      chk("R2 all filled", fill_mask, exp_m);
    end
    nxt(); put(0, 26'h310, 0); put(1, 26'h310, 1); put(2, 26'h311, 0); #1;
    chk("R2 mixed ack", req_ack, 8'h03);
    chk("R2 mixed addr", ic_req_addr, 26'h310);
    nxt(); put(2, 26'h311, 0); #1;
    chk("R2 second fetch", ic_req_addr, 26'h311);
    nxt(); give(26'h310); #1; chk("R2 mixed fill", fill_mask, 16'h0009);
    nxt(); give(26'h311); #1; chk("R2 other fill", fill_mask, bit_of(2,0));

    // R6: flush drops ownership
    nxt(); put(4, 26'h400, 0); #1; chk("R6 fetch", ic_req_valid, 1);
    nxt(); put(6, 26'h400, 1); #1; chk("R6 merge", req_ack, 8'h40);
    nxt(); flush[4] = 1'b1; put(4, 26'h401, 0); #1;
    chk("R6 flushed no ack", req_ack, 0);
    chk("R6 flushed no fetch", ic_req_valid, 0);
    nxt(); give(26'h400); #1;
    chk("R6 only survivor", fill_mask, bit_of(6,1));
    nxt(); put(0, 26'h410, 1); #1; chk("R6 fetch2", ic_req_valid, 1);
    nxt(); give(26'h410); flush[0] = 1'b1; #1;
    chk("R6 flush on return", fill_mask, 0);

    // R7: fully flushed entry freed
    nxt(); put(7, 26'h500, 0); #1; chk("R7 fetch", ic_req_valid, 1);
    nxt(); flush[7] = 1'b1;
    nxt(); put(7, 26'h500, 0); #1;
    chk("R7 refetch", ic_req_valid, 1);
    chk("R7 refetch addr", ic_req_addr, 26'h500);
    nxt(); give(26'h500); #1; chk("R7 fill", fill_mask, bit_of(7,0));

    // R8: full table stalls
    for (int i = 0; i < NT; i++) begin
      nxt(); put(i, 26'h600 + 26'(i), 0); #1;
      chk("R8 fill table", ic_req_valid, 1);
    end
    nxt(); put(0, 26'h6FF, 0); #1;
    chk("R8 stall ack", req_ack, 0);
    chk("R8 stall fetch", ic_req_valid, 0);
    nxt(); put(0, 26'h6FF, 0); give(26'h603); #1;
    chk("R8 still stalled", ic_req_valid, 0);
    chk("R8 return fill", fill_mask, bit_of(3,0));
    nxt(); put(0, 26'h6FF, 0); #1;
    chk("R8 freed used", ic_req_valid, 1);
    chk("R8 freed ack", req_ack, 8'h01);
    for (int i = 0; i < NT; i++) begin
      if (i != 3) begin
        nxt(); give(26'h600 + 26'(i)); #1;
        chk("R8 drain", fill_mask, bit_of(i,0));
      end
    end
    nxt(); give(26'h6FF); #1; chk("R8 drain last", fill_mask, bit_of(0,0));

    // R9: request meets its own return
    nxt(); put(1, 26'h700, 0); #1; chk("R9 fetch", ic_req_valid, 1);
    nxt(); give(26'h700); put(2, 26'h700, 1); #1;
    chk("R9 joint fill", fill_mask, bit_of(1,0) | bit_of(2,1));
    chk("R9 ack", req_ack, 8'h04);
    chk("R9 no fetch", ic_req_valid, 0);
    nxt(); give(26'h700); #1; chk("R9 no alloc", fill_mask, 0);
    nxt(); give(26'h710); put(3, 26'h710, 0); #1;
    chk("R9 orphan return", fill_mask, bit_of(3,0));
    chk("R9 orphan no fetch", ic_req_valid, 0);

    // R4: sweep every thread and slot
    for (int t = 0; t < NT; t++) begin
      for (int s = 0; s < 2; s++) begin
        nxt(); put(t, 26'h800 + 26'(t*2 + s), s); #1;
        chk("R4 sweep ack", req_ack, 8'(1) << t);
        nxt(); give(26'h800 + 26'(t*2 + s)); #1;
        chk("R4 sweep fill", fill_mask, bit_of(t, s));
      end
    end

    nxt();
    summary();
    $finish;
  end

endmodule